// File: doc/BRIEF.md
# Shared-Bus Data Transfer Unit

This block is an 8-bit datapath in which every move of data crosses one internal bus. Three sources can drive that bus: the input port, a working register and a small register-file RAM. Four destinations can capture it: the working register, an output port register, a RAM address register and the RAM itself. An external controller supplies seven separate control lines each cycle. Three of them are source drive enables and four are destination load enables, so one control word describes one transfer. All destinations update on the same rising clock edge.

The bus models tristate drivers. Each source is gated by its own enable and the gated values are OR-ed together. When no source drives, a bus keeper presents the last value that was driven. This lets the address register be loaded from the bus with no source active in the same cycle. If more than one source is enabled at once, the cycle is discarded and a registered conflict flag is raised. A chip-select input gates every access to the RAM.

Top module: `xfer_bus_unit`

## Requirements
- R1: A synchronous active-high reset clears the working register, the output port, the address register, the bus keeper and every RAM location, and clears `bus_conflict`.
- R2: With `ctl_in_drv` and `ctl_work_ld` high, the working register takes `in_port` on the clock edge.
- R3: With `ctl_addr_ld` high, the address register takes the low 4 bits of the bus value. That value selects the RAM location for later reads and writes.
- R4: With `ctl_work_drv` and `ctl_mem_wr` high and `mem_cs` high, the working register value is written to the selected RAM location.
- R5: With `ctl_work_drv` and `ctl_out_ld` high, `out_port` shows the working register value one edge later.
- R6: With `ctl_mem_rd` high, the selected RAM location drives the bus. Together with `ctl_work_ld` it loads the working register; together with `ctl_out_ld` it loads `out_port`.
- R7: With `ctl_in_drv` and `ctl_mem_wr` high, `in_port` is written directly into the selected RAM location.
- R8: If two or more of `ctl_mem_rd`, `ctl_in_drv` and `ctl_work_drv` are high, every destination (including RAM and the bus keeper) keeps its value, and `bus_conflict` reads 1 after that edge. After a cycle with at most one source, `bus_conflict` reads 0.
- R9: With `mem_cs` low, RAM writes have no effect and a RAM read drives 0 onto the bus.
- R10: With no source enabled, the bus carries the last value driven by exactly one source (0 after reset), and destinations capture that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_addr_ld | input | 1 | Load address register from bus |
| ctl_mem_rd | input | 1 | RAM drives the bus (source) |
| ctl_mem_wr | input | 1 | Write bus into selected RAM location |
| ctl_in_drv | input | 1 | Input port drives the bus (source) |
| ctl_out_ld | input | 1 | Load output port register from bus |
| ctl_work_ld | input | 1 | Load working register from bus |
| ctl_work_drv | input | 1 | Working register drives the bus (source) |
| mem_cs | input | 1 | RAM chip select, gates read and write |
| in_port | input | 8 | Input port data |
| out_port | output | 8 | Output port register |
| bus_conflict | output | 1 | Registered flag: last cycle had more than one source |

## Verification
The assertions assume that control lines and `in_port` are stable around each rising edge. They also assume reset is held for at least one edge before any checked transfer, so every `$past` value they use comes from a defined cycle. The bench drives all inputs on the falling edge. It releases reset only through its next transfer and does not change `mem_cs` within a cycle. Conflicting control words are produced on purpose, so the hold behaviour is tested directly rather than excluded.

// File: rtl/xbu_pkg.sv
`timescale 1ns/1ps
package xbu_pkg;
  localparam int SRC_N    = 3;
  localparam int SRC_MEM  = 0;
  localparam int SRC_IN   = 1;
  localparam int SRC_WORK = 2;
endpackage

// File: rtl/xbu_bus_sel.sv
`timescale 1ns/1ps
// Wired-OR model of tristate drivers plus a bus keeper.
module xbu_bus_sel #(
  parameter int DATA_W = 8,
  parameter int SRC_N  = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SRC_N-1:0]               drv_en,
  input  logic [SRC_N-1:0][DATA_W-1:0]   drv_data,
  output logic [DATA_W-1:0]              bus,
  output logic                           single,
  output logic                           conflict
);
  localparam int CNT_W = $clog2(SRC_N + 1);

  logic [SRC_N-1:0][DATA_W-1:0] gated;
  logic [DATA_W-1:0]            wired;
  logic [DATA_W-1:0]            keep_q;
  logic [CNT_W-1:0]             n_active;

  genvar g;
  generate
    for (g = 0; g < SRC_N; g++) begin : g_drv
      assign gated[g] = drv_data[g] & {DATA_W{drv_en[g]}};
    end
  endgenerate

  always_comb begin
    wired    = '0;
    n_active = '0;
    for (int i = 0; i < SRC_N; i++) begin
      wired    = wired | gated[i];
      n_active = n_active + CNT_W'(drv_en[i]);
    end
  end

  assign single   = (n_active == CNT_W'(1));
  assign conflict = (n_active > CNT_W'(1));
  assign bus      = single ? wired : keep_q;

  always_ff @(posedge clk) begin
    if (rst)         keep_q <= '0;
    else if (single) keep_q <= wired;
  end

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (single ##1 (drv_en == '0)) |-> (bus == $past(bus)));
endmodule

// File: rtl/xbu_regfile.sv
`timescale 1ns/1ps
// Small register-file RAM, asynchronous read, clearable on reset.
module xbu_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && cs) begin
      mem[addr] <= wdata;
    end
  end

  assign rd_data = cs ? mem[addr] : '0;

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cs) |=> (mem[$past(addr)] == $past(wdata)));

  // R9
  deselect_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs) |=> (mem[$past(addr)] == $past(mem[addr])));
endmodule

// File: rtl/xbu_dreg.sv
`timescale 1ns/1ps
// Loadable destination register with synchronous reset.
module xbu_dreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/xfer_bus_unit.sv
`timescale 1ns/1ps
module xfer_bus_unit #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_addr_ld,
  input  logic              ctl_mem_rd,
  input  logic              ctl_mem_wr,
  input  logic              ctl_in_drv,
  input  logic              ctl_out_ld,
  input  logic              ctl_work_ld,
  input  logic              ctl_work_drv,
  input  logic              mem_cs,
  input  logic [DATA_W-1:0] in_port,
  output logic [DATA_W-1:0] out_port,
  output logic              bus_conflict
);
  import xbu_pkg::*;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [SRC_N-1:0]             drv_en;
  logic [SRC_N-1:0][DATA_W-1:0] drv_data;
  logic [DATA_W-1:0]            bus;
  logic                         single;
  logic                         conflict;
  logic                         commit;
  logic [DATA_W-1:0]            work_q;
  logic [DATA_W-1:0]            ram_rd;
  logic [ADDR_W-1:0]            addr_q;
  logic                         flag_q;

  assign drv_en[SRC_MEM]    = ctl_mem_rd;
  assign drv_en[SRC_IN]     = ctl_in_drv;
  assign drv_en[SRC_WORK]   = ctl_work_drv;
  assign drv_data[SRC_MEM]  = ram_rd;
  assign drv_data[SRC_IN]   = in_port;
  assign drv_data[SRC_WORK] = work_q;

  xbu_bus_sel #(.DATA_W(DATA_W), .SRC_N(SRC_N)) u_bus (
    .clk(clk), .rst(rst), .drv_en(drv_en), .drv_data(drv_data),
    .bus(bus), .single(single), .conflict(conflict)
  );

  assign commit = !conflict;

  xbu_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .cs(mem_cs), .wr_en(ctl_mem_wr && commit),
    .addr(addr_q), .wdata(bus), .rd_data(ram_rd)
  );

  xbu_dreg #(.W(DATA_W)) u_work (
    .clk(clk), .rst(rst), .ld(ctl_work_ld && commit), .d(bus), .q(work_q)
  );

  xbu_dreg #(.W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .ld(ctl_out_ld && commit), .d(bus), .q(out_port)
  );

  xbu_dreg #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .ld(ctl_addr_ld && commit), .d(bus[ADDR_W-1:0]), .q(addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= conflict;
  end
  assign bus_conflict = flag_q;

  // R8
  conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
    conflict |=> bus_conflict);

  // R8
  conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    conflict |=> ($stable(out_port) && $stable(work_q) && $stable(addr_q)));

  // R2
  work_from_input_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_in_drv && !ctl_mem_rd && !ctl_work_drv && ctl_work_ld) |=> (work_q == $past(in_port)));

  // R3
  addr_from_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_addr_ld && single) |=> (addr_q == $past(bus[ADDR_W-1:0])));

  // R5
  out_from_work_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_work_drv && !ctl_mem_rd && !ctl_in_drv && ctl_out_ld) |=> (out_port == $past(work_q)));
endmodule

// File: tb/test_xfer_bus_unit.sv
`timescale 1ns/1ps
module test_xfer_bus_unit;
  localparam int CLK_PERIOD = 10;

  // control word bit order: {addr_ld, mem_rd, mem_wr, in_drv, out_ld, work_ld, work_drv}
  localparam logic [6:0] C_ALD = 7'b1000000;
  localparam logic [6:0] C_MRD = 7'b0100000;
  localparam logic [6:0] C_MWR = 7'b0010000;
  localparam logic [6:0] C_IN  = 7'b0001000;
  localparam logic [6:0] C_OLD = 7'b0000100;
  localparam logic [6:0] C_WLD = 7'b0000010;
  localparam logic [6:0] C_WDR = 7'b0000001;

  logic clk = 0, rst = 1;
  logic ctl_addr_ld = 0, ctl_mem_rd = 0, ctl_mem_wr = 0, ctl_in_drv = 0;
  logic ctl_out_ld = 0, ctl_work_ld = 0, ctl_work_drv = 0, mem_cs = 1;
  logic [7:0] in_port = 0;
  logic [7:0] out_port;
  logic bus_conflict;

  xfer_bus_unit i_xfer_bus_unit (
    .clk(clk), .rst(rst), .ctl_addr_ld(ctl_addr_ld), .ctl_mem_rd(ctl_mem_rd),
    .ctl_mem_wr(ctl_mem_wr), .ctl_in_drv(ctl_in_drv), .ctl_out_ld(ctl_out_ld),
    .ctl_work_ld(ctl_work_ld), .ctl_work_drv(ctl_work_drv), .mem_cs(mem_cs),
    .in_port(in_port), .out_port(out_port), .bus_conflict(bus_conflict)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] out_e;
    logic       conf_e;
    string      tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_work, m_out, m_keep;
  logic [3:0] m_addr;
  logic [7:0] m_ram [16];

  task automatic model_clear();
    m_work = 0; m_out = 0; m_keep = 0; m_addr = 0;
    for (int i = 0; i < 16; i++) m_ram[i] = 0;
  endtask

  task automatic do_reset(input string tag);
    exp_t e;
    @(negedge clk);
    rst = 1;
    {ctl_addr_ld, ctl_mem_rd, ctl_mem_wr, ctl_in_drv, ctl_out_ld, ctl_work_ld, ctl_work_drv} = '0;
    model_clear();
    e.out_e = 0; e.conf_e = 0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic apply(input logic [6:0] w, input logic [7:0] din, input logic cs, input string tag);
    exp_t e;
    int nsrc;
    logic [7:0] b;
    @(negedge clk);
    rst = 0;
    {ctl_addr_ld, ctl_mem_rd, ctl_mem_wr, ctl_in_drv, ctl_out_ld, ctl_work_ld, ctl_work_drv} = w;
    in_port = din;
    mem_cs = cs;
    nsrc = int'(w[5]) + int'(w[3]) + int'(w[0]);
    e.conf_e = (nsrc > 1);
    if (nsrc <= 1) begin
      if (nsrc == 1) begin
        if (w[5])      b = cs ? m_ram[m_addr] : 8'h00;
        else if (w[3]) b = din;
        else           b = m_work;
        m_keep = b;
      end else begin
        b = m_keep;
      end
      if (w[4] && cs) m_ram[m_addr] = b;
      if (w[6]) m_addr = b[3:0];
      if (w[1]) m_work = b;
      if (w[2]) m_out = b;
    end
    e.out_e = m_out; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (out_port !== e.out_e) begin
          errors++;
          $display("FAIL %s out_port actual=%h expected=%h", e.tag, out_port, e.out_e);
        end
        checks++;
        if (bus_conflict !== e.conf_e) begin
          errors++;
          $display("FAIL %s bus_conflict actual=%b expected=%b", e.tag, bus_conflict, e.conf_e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state");
    // R3 R7: input drives bus into address, then straight into RAM
    apply(C_IN | C_ALD, 8'h05, 1, "R3 addr from input");
    apply(C_IN | C_MWR, 8'hA5, 1, "R7 input into ram");
    apply(C_MRD | C_OLD, 8'h00, 1, "R7 ram readback");
    do_reset("R1 reset again");
    apply(C_IN | C_ALD, 8'h05, 1, "R3 addr after reset");
    apply(C_MRD | C_OLD, 8'h00, 1, "R1 ram cleared");
    // R2 R5
    apply(C_IN | C_WLD, 8'h3C, 1, "R2 input to work");
    apply(C_WDR | C_OLD, 8'h00, 1, "R5 work to out");
    // R10 R3: address loaded with no source active
    apply(C_IN | C_WLD, 8'h19, 1, "R2 input to work");
    apply(C_ALD, 8'hFF, 1, "R10 addr from keeper");
    apply(C_WDR | C_MWR, 8'h00, 1, "R4 work into ram");
    apply(C_IN | C_WLD, 8'h00, 1, "R2 clear work");
    apply(C_IN | C_ALD, 8'h09, 1, "R3 reselect loc");
    apply(C_MRD | C_WLD, 8'h00, 1, "R6 ram to work");
    apply(C_WDR | C_OLD, 8'h00, 1, "R6 work shows ram");
    apply(C_IN | C_ALD, 8'h02, 1, "R3 other loc");
    apply(C_MRD | C_OLD, 8'h00, 1, "R6 ram loc2 zero");
    apply(C_IN | C_ALD, 8'h09, 1, "R3 back to loc9");
    apply(C_MRD | C_OLD, 8'h00, 1, "R6 ram to out");
    // R10 idle bus
    apply(C_IN | C_WLD, 8'h77, 1, "R2 input to work");
    apply(C_OLD, 8'h00, 1, "R10 out from keeper");
    // R8 conflicts
    apply(C_IN | C_WDR | C_OLD, 8'hEE, 1, "R8 conflict in+work");
    apply(C_IN | C_MRD | C_WLD | C_OLD | C_MWR, 8'hDD, 1, "R8 conflict in+ram");
    apply(C_WDR | C_OLD, 8'h00, 1, "R8 work kept");
    apply(C_OLD, 8'h00, 1, "R8 keeper kept");
    apply(C_MRD | C_OLD, 8'h00, 1, "R8 ram kept");
    // R9 chip select
    apply(C_IN | C_MWR, 8'h55, 0, "R9 write deselected");
    apply(C_MRD | C_OLD, 8'h00, 1, "R9 ram unchanged");
    apply(C_MRD | C_OLD, 8'h00, 0, "R9 read deselected");
    apply(C_WDR | C_MWR, 8'h00, 1, "R4 write work");
    apply(C_MRD | C_OLD, 8'h00, 1, "R4 readback");
    @(posedge clk); #2;
    @(posedge clk); #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule